// File: doc/BRIEF.md
# Split/Joined Capture Timer-Counter

This block is a timer/counter with two 8-bit halves. A 2-bit mode field chooses how the halves work. In split operation each half is its own counter with its own match value and its own interrupt pulse. In joined operation the halves form one 16-bit counter that compares against both match bytes together. In every mode except the pure event mode, counting advances on ticks from a shared programmable 8-bit prescaler. The prescaler itself moves only in cycles where the clock-enable input is high. Event counting advances on each rising edge of the event input.

Two capture trigger inputs each own one 16-bit capture register. A rising edge on a trigger stores the full count: low half in the low byte, high half in the high byte. In split modes the two bytes are two independent 8-bit captures. In joined modes they are one coherent 16-bit capture. A small write port loads the mode, the prescaler limit and the two match bytes. Writing the mode restarts the counters and the prescaler.

Top module: `capture_timer`

## Requirements
- R1: After a synchronous active-low reset the behaviour is as follows. Both capture registers and both interrupt outputs are 0. The mode is 0 and the prescaler limit is 0. Both match bytes are 0xFF. The counters and the prescaler start at 0.
- R2: The prescaler counts cycles in which `tick_en` is 1. It issues one tick each time its count reaches or passes the limit P, and then restarts from 0. This gives one tick every P+1 enabled cycles. With `tick_en` at 0, no prescaled counter moves.
- R3: Mode 0 has both halves as independent 8-bit counters, each advanced by the prescaler tick.
- R4: Mode 1 has the low half advanced by the prescaler tick and the high half advanced by each rising edge of `evt_in`. Rising edges of `evt_in` are counted whatever the value of `tick_en`.
- R5: Mode 2 joins the halves into one 16-bit counter advanced by the prescaler tick. Its match value is {high match byte, low match byte}. `irq_lo` stays 0 in modes 2 and 3.
- R6: Mode 3 joins the halves into one 16-bit counter advanced by each rising edge of `evt_in`. The count does not change in any other cycle.
- R7: When a counter advances while it equals its match value, it returns to 0. Its interrupt output is then 1 for the following cycle. Otherwise it adds 1. In split modes the low half drives `irq_lo` and the high half drives `irq_hi`. In joined modes a 16-bit match drives `irq_hi`.
- R8: A rising edge on `cap_a_in` or `cap_b_in` copies the count into `cap_a` or `cap_b` in that same cycle. The value copied is the count before that cycle's update, as {high half, low half}. Without an edge the capture register holds.
- R9: A write to the mode address clears both counters, the prescaler and any pending interrupt pulse. No count or event is taken in the write cycle. Writes to the other addresses change no count.
- R10: The write port decodes `wr_addr` as follows. 0 is the mode, taken from `wr_data[1:0]`. 1 is the prescaler limit. 2 is the low match byte. 3 is the high match byte. Each new value takes effect from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | Clock enable for the prescaler |
| evt_in | input | 1 | External event input, counted on rising edges |
| cap_a_in | input | 1 | Capture trigger for register A |
| cap_b_in | input | 1 | Capture trigger for register B |
| wr_en | input | 1 | Configuration write strobe |
| wr_addr | input | 2 | Configuration register select |
| wr_data | input | 8 | Configuration write data |
| cap_a | output | 16 | Capture register A |
| cap_b | output | 16 | Capture register B |
| irq_lo | output | 1 | Low-half match pulse |
| irq_hi | output | 1 | High-half or 16-bit match pulse |

## Verification
The assertions assume three things about the inputs. The event and trigger inputs are already synchronous to `clk`. They are free of unknown values. They are low when reset is released, so that the first cycle does not see a false rising edge. The stimulus meets all three. It changes every input only on the falling clock edge, and it holds all of them at 0 while `rst_n` is low. Writes are single-cycle pulses, and the mode field is always given one of the four defined codes.

// File: rtl/ctmr_pkg.sv
// Shared types and the configuration address map of the capture timer.
package ctmr_pkg;
    typedef enum logic [1:0] {
        MODE_SPLIT_TMR = 2'd0,
        MODE_SPLIT_MIX = 2'd1,
        MODE_JOIN_TMR  = 2'd2,
        MODE_JOIN_EVT  = 2'd3
    } ctmr_mode_e;

    localparam logic [1:0] ADDR_MODE = 2'd0;
    localparam logic [1:0] ADDR_PRE  = 2'd1;
    localparam logic [1:0] ADDR_MLO  = 2'd2;
    localparam logic [1:0] ADDR_MHI  = 2'd3;
endpackage

// File: rtl/ctmr_edge.sv
// Rising-edge detector for N single-bit inputs.
// Assumes the inputs are already synchronous to clk. The history resets to 0.
module ctmr_edge #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] sig_in,
    output logic [N-1:0] rise
);
    logic [N-1:0] prev_q;

    // Keep the previous value of each input.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= sig_in;
    end

    assign rise = sig_in & ~prev_q;
endmodule

// File: rtl/ctmr_prescaler.sv
// Programmable clock-enable divider. It counts enabled cycles and gives one
// tick each time the count reaches or passes the limit. The >= compare lets a
// smaller limit written mid-count take hold at once.
// Assumes clr has priority over counting.
module ctmr_prescaler #(
    parameter int PRE_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             tick_en,
    input  logic [PRE_W-1:0] limit,
    output logic             tick
);
    localparam logic [PRE_W-1:0] PRE_ONE = {{(PRE_W-1){1'b0}}, 1'b1};

    logic [PRE_W-1:0] div_q;
    logic             at_limit;

    assign at_limit = (div_q >= limit);
    assign tick     = tick_en & ~clr & at_limit;

    // Advance the divider on enabled cycles and restart it at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n)       div_q <= '0;
        else if (clr)     div_q <= '0;
        else if (tick_en) div_q <= at_limit ? '0 : div_q + PRE_ONE;
    end
endmodule

// File: rtl/ctmr_count_core.sv
// Two HALF_W counter halves that run apart (split) or as one 2*HALF_W counter
// (joined). Each counter returns to zero when it advances from its match value,
// and gives a one-cycle wrap pulse. In joined operation only wrap_hi pulses.
// Assumes the increment inputs are already qualified by clr.
module ctmr_count_core #(
    parameter int HALF_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clr,
    input  logic                joined,
    input  logic                inc_lo,
    input  logic                inc_hi,
    input  logic [HALF_W-1:0]   match_lo,
    input  logic [HALF_W-1:0]   match_hi,
    output logic [2*HALF_W-1:0] count,
    output logic                wrap_lo,
    output logic                wrap_hi
);
    localparam int CNT_W = 2 * HALF_W;
    localparam logic [HALF_W-1:0] HALF_ONE = {{(HALF_W-1){1'b0}}, 1'b1};
    localparam logic [CNT_W-1:0]  FULL_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    logic [CNT_W-1:0]             cnt_q, cnt_d;
    logic                         wlo_q, whi_q, wlo_d, whi_d;
    logic [1:0]                   half_inc, half_eq, half_hit;
    logic [1:0][HALF_W-1:0]       half_match, half_cur, half_next;
    logic                         full_hit;

    assign half_inc   = {inc_hi, inc_lo};
    assign half_match = {match_hi, match_lo};

    for (genvar h = 0; h < 2; h++) begin : g_half
        assign half_cur[h]  = cnt_q[h*HALF_W +: HALF_W];
        assign half_eq[h]   = (half_cur[h] == half_match[h]);
        assign half_hit[h]  = half_inc[h] & half_eq[h];
        assign half_next[h] = !half_inc[h] ? half_cur[h] :
                              (half_hit[h] ? '0 : half_cur[h] + HALF_ONE);
    end

    // The joined match reuses the two half comparators.
    assign full_hit = inc_lo & half_eq[0] & half_eq[1];

    // Pick the next count and the wrap pulses for the current arrangement.
    always_comb begin
        if (joined) begin
            cnt_d = !inc_lo ? cnt_q : (full_hit ? '0 : cnt_q + FULL_ONE);
            wlo_d = 1'b0;
            whi_d = full_hit;
        end else begin
            cnt_d = {half_next[1], half_next[0]};
            wlo_d = half_hit[0];
            whi_d = half_hit[1];
        end
    end

    // Register the count and the wrap pulses; clr restarts everything.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt_q <= '0;
            wlo_q <= 1'b0;
            whi_q <= 1'b0;
        end else begin
            cnt_q <= cnt_d;
            wlo_q <= wlo_d;
            whi_q <= whi_d;
        end
    end

    assign count   = cnt_q;
    assign wrap_lo = wlo_q;
    assign wrap_hi = whi_q;
endmodule

// File: rtl/ctmr_capture.sv
// N capture registers of width W. Channel i loads value when grab[i] is high.
// Assumes grab is already a single-cycle edge strobe.
module ctmr_capture #(
    parameter int W = 16,
    parameter int N = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [N-1:0]        grab,
    input  logic [W-1:0]        value,
    output logic [N-1:0][W-1:0] held
);
    for (genvar c = 0; c < N; c++) begin : g_chan
        // Load this channel on its strobe, otherwise hold.
        always_ff @(posedge clk) begin
            if (!rst_n)       held[c] <= '0;
            else if (grab[c]) held[c] <= value;
        end
    end
endmodule

// File: rtl/capture_timer.sv
// Split/joined capture timer-counter top level. It holds the configuration
// registers, chooses the increment source of each half from the mode, and
// connects the prescaler, counter core, edge detectors and capture registers.
// Assumes: inputs synchronous to clk; PRE_W <= HALF_W.
module capture_timer #(
    parameter int HALF_W = 8,
    parameter int PRE_W  = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick_en,
    input  logic                evt_in,
    input  logic                cap_a_in,
    input  logic                cap_b_in,
    input  logic                wr_en,
    input  logic [1:0]          wr_addr,
    input  logic [HALF_W-1:0]   wr_data,
    output logic [2*HALF_W-1:0] cap_a,
    output logic [2*HALF_W-1:0] cap_b,
    output logic                irq_lo,
    output logic                irq_hi
);
    import ctmr_pkg::*;

    localparam int CNT_W = 2 * HALF_W;

    ctmr_mode_e             mode_q;
    logic [PRE_W-1:0]       pre_q;
    logic [HALF_W-1:0]      mlo_q, mhi_q;
    logic                   mode_wr, joined, pre_tick, evt_rise;
    logic                   inc_lo, inc_hi;
    logic [2:0]             rise;
    logic [1:0]             cap_rise;
    logic [CNT_W-1:0]       count;
    logic [1:0][CNT_W-1:0]  cap_bank;

    assign mode_wr  = wr_en && (wr_addr == ADDR_MODE);
    assign joined   = mode_q[1];
    assign evt_rise = rise[0] & ~mode_wr;
    assign cap_rise = rise[2:1];

    // Configuration registers written through the port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= MODE_SPLIT_TMR;
            pre_q  <= '0;
            mlo_q  <= '1;
            mhi_q  <= '1;
        end else if (wr_en) begin
            case (wr_addr)
                ADDR_MODE: mode_q <= ctmr_mode_e'(wr_data[1:0]);
                ADDR_PRE:  pre_q  <= wr_data[PRE_W-1:0];
                ADDR_MLO:  mlo_q  <= wr_data;
                default:   mhi_q  <= wr_data;
            endcase
        end
    end

    // Choose the increment source of each half from the mode.
    always_comb begin
        case (mode_q)
            MODE_SPLIT_TMR: begin inc_lo = pre_tick; inc_hi = pre_tick; end
            MODE_SPLIT_MIX: begin inc_lo = pre_tick; inc_hi = evt_rise; end
            MODE_JOIN_TMR:  begin inc_lo = pre_tick; inc_hi = 1'b0;     end
            default:        begin inc_lo = evt_rise; inc_hi = 1'b0;     end
        endcase
    end

    ctmr_edge #(.N(3)) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .sig_in ({cap_b_in, cap_a_in, evt_in}),
        .rise   (rise)
    );

    ctmr_prescaler #(.PRE_W(PRE_W)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (mode_wr),
        .tick_en (tick_en),
        .limit   (pre_q),
        .tick    (pre_tick)
    );

    ctmr_count_core #(.HALF_W(HALF_W)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (mode_wr),
        .joined   (joined),
        .inc_lo   (inc_lo),
        .inc_hi   (inc_hi),
        .match_lo (mlo_q),
        .match_hi (mhi_q),
        .count    (count),
        .wrap_lo  (irq_lo),
        .wrap_hi  (irq_hi)
    );

    ctmr_capture #(.W(CNT_W), .N(2)) u_cap (
        .clk   (clk),
        .rst_n (rst_n),
        .grab  (cap_rise),
        .value (count),
        .held  (cap_bank)
    );

    assign cap_a = cap_bank[0];
    assign cap_b = cap_bank[1];
endmodule

// File: rtl/ctmr_checker.sv
// Property checker for capture_timer, attached by bind.
// Assumes synchronous, known inputs that are low at reset release.
module ctmr_checker #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             mode_wr,
    input logic             joined,
    input logic [1:0]       mode_q,
    input logic             evt_rise,
    input logic             pre_tick,
    input logic [1:0]       cap_rise,
    input logic [CNT_W-1:0] count,
    input logic [CNT_W-1:0] cap_a,
    input logic [CNT_W-1:0] cap_b,
    input logic             irq_lo,
    input logic             irq_hi
);
    localparam int HW = CNT_W / 2;

    AST_CAP_A_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_rise[0] |=> $stable(cap_a)); // R8
    AST_CAP_B_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
        cap_rise[1] |=> (cap_b == $past(count))); // R8
    AST_JOIN_NO_LO: assert property (@(posedge clk) disable iff (!rst_n)
        joined |-> !irq_lo); // R5
    AST_MODE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        mode_wr |=> (count == '0) && !irq_lo && !irq_hi); // R9
    AST_WRAP_HALF_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_hi && !joined) |-> (count[CNT_W-1:HW] == '0)); // R7
    AST_WRAP_FULL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_hi && joined) |-> (count == '0)); // R7
    AST_EVT_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == 2'd3 && !evt_rise && !mode_wr) |=> $stable(count)); // R6
    AST_PRE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == 2'd2 && !pre_tick && !mode_wr) |=> $stable(count)); // R2
endmodule

bind capture_timer ctmr_checker #(.CNT_W(2*HALF_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode_wr  (mode_wr),
    .joined   (joined),
    .mode_q   (mode_q),
    .evt_rise (evt_rise),
    .pre_tick (pre_tick),
    .cap_rise (cap_rise),
    .count    (count),
    .cap_a    (cap_a),
    .cap_b    (cap_b),
    .irq_lo   (irq_lo),
    .irq_hi   (irq_hi)
);

// File: tb/capture_timer_tb.sv
// Self-checking bench: a behavioural model built from the requirements runs
// beside the design and is compared at every falling edge.
module capture_timer_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0, evt_in = 1'b0, cap_a_in = 1'b0, cap_b_in = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = 2'd0;
    logic [7:0]  wr_data = 8'd0;
    logic [15:0] cap_a, cap_b;
    logic        irq_lo, irq_hi;

    int    checks = 0;
    int    errors = 0;
    bit    checking = 1'b0;
    string cur_tag = "R1 reset";

    // model state
    logic [1:0]  m_mode;
    logic [7:0]  m_pre, m_mlo, m_mhi, m_div, m_lo, m_hi;
    logic [15:0] m_capa, m_capb, m_full;
    logic        m_ilo, m_ihi, m_eq, m_aq, m_bq;
    logic        m_wr, m_er, m_pt, m_ra, m_rb;
    logic [8:0]  m_step;

    capture_timer u_dut (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .evt_in(evt_in),
        .cap_a_in(cap_a_in), .cap_b_in(cap_b_in), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .cap_a(cap_a), .cap_b(cap_b),
        .irq_lo(irq_lo), .irq_hi(irq_hi)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // R7 step of one 8-bit counter: {hit, next value}
    function automatic logic [8:0] step8(input logic [7:0] c, input logic [7:0] m,
                                         input logic inc);
        if (!inc)        return {1'b0, c};
        else if (c == m) return {1'b1, 8'd0};
        else             return {1'b0, c + 8'd1};
    endfunction

    // Reference model, advanced on each rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_mode = 2'd0; m_pre = 8'd0; m_mlo = 8'hFF; m_mhi = 8'hFF;
            m_div = 8'd0; m_lo = 8'd0; m_hi = 8'd0; m_capa = 16'd0; m_capb = 16'd0;
            m_ilo = 1'b0; m_ihi = 1'b0; m_eq = 1'b0; m_aq = 1'b0; m_bq = 1'b0;
        end else begin
            m_wr = wr_en && (wr_addr == 2'd0);
            m_er = evt_in && !m_eq && !m_wr;
            m_ra = cap_a_in && !m_aq;
            m_rb = cap_b_in && !m_bq;
            m_pt = tick_en && !m_wr && (m_div >= m_pre);
            if (m_ra) m_capa = {m_hi, m_lo};
            if (m_rb) m_capb = {m_hi, m_lo};
            if (m_wr) m_div = 8'd0;
            else if (tick_en) m_div = (m_div >= m_pre) ? 8'd0 : m_div + 8'd1;
            if (m_wr) begin
                m_lo = 8'd0; m_hi = 8'd0; m_ilo = 1'b0; m_ihi = 1'b0;
            end else if (m_mode[1] == 1'b0) begin
                m_step = step8(m_lo, m_mlo, m_pt);
                m_lo = m_step[7:0]; m_ilo = m_step[8];
                m_step = step8(m_hi, m_mhi, (m_mode == 2'd0) ? m_pt : m_er);
                m_hi = m_step[7:0]; m_ihi = m_step[8];
            end else begin
                m_full = {m_hi, m_lo};
                m_ilo = 1'b0; m_ihi = 1'b0;
                if ((m_mode == 2'd2) ? m_pt : m_er) begin
                    if (m_full == {m_mhi, m_mlo}) begin m_full = 16'd0; m_ihi = 1'b1; end
                    else m_full = m_full + 16'd1;
                end
                {m_hi, m_lo} = m_full;
            end
            if (wr_en) begin
                case (wr_addr)
                    2'd0: m_mode = wr_data[1:0];
                    2'd1: m_pre  = wr_data;
                    2'd2: m_mlo  = wr_data;
                    default: m_mhi = wr_data;
                endcase
            end
            m_eq = evt_in; m_aq = cap_a_in; m_bq = cap_b_in;
        end
    end

    task automatic check(input bit ok, input string what, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", cur_tag, what, act, exp);
        end
    endtask

    // Compare the outputs with the model at every falling edge.
    always @(negedge clk) begin
        if (checking && rst_n) begin
            check(cap_a === m_capa, "R8 cap_a", {16'd0, cap_a}, {16'd0, m_capa});
            check(cap_b === m_capb, "R8 cap_b", {16'd0, cap_b}, {16'd0, m_capb});
            check(irq_lo === m_ilo, "R7 irq_lo", {31'd0, irq_lo}, {31'd0, m_ilo});
            check(irq_hi === m_ihi, "R7 irq_hi", {31'd0, irq_hi}, {31'd0, m_ihi});
        end
    end

    task automatic write_reg(input logic [1:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic run_rand(input int cycles, input int tick_pct, input bit pre_writes);
        for (int i = 0; i < cycles; i++) begin
            tick_en = (($urandom % 100) < tick_pct);
            if (($urandom % 3) == 0) evt_in = ~evt_in;
            if (($urandom % 8) == 0) cap_a_in = ~cap_a_in;
            if (($urandom % 9) == 0) cap_b_in = ~cap_b_in;
            if (pre_writes && (($urandom % 200) == 0)) write_reg(2'd1, 8'($urandom % 4));
            else @(negedge clk);
        end
        cap_a_in = 1'b0; cap_b_in = 1'b0; evt_in = 1'b0;
        @(negedge clk);
    endtask

    task automatic setup(input logic [1:0] md, input logic [7:0] pre,
                         input logic [7:0] mlo, input logic [7:0] mhi);
        write_reg(2'd1, pre);   // R10 prescaler limit
        write_reg(2'd2, mlo);   // R10 low match
        write_reg(2'd3, mhi);   // R10 high match
        write_reg(2'd0, {6'd0, md}); // R10 mode
    endtask

    // Watchdog: a hung run is a failed check.
    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        checking = 1'b1;
        @(negedge clk);
        // R1 reset values at the ports
        cur_tag = "R1 reset";
        check(cap_a === 16'd0 && cap_b === 16'd0, "R1 captures", {cap_a, cap_b}, 32'd0);
        check(!irq_lo && !irq_hi, "R1 irqs", {30'd0, irq_lo, irq_hi}, 32'd0);
        // R1 defaults: limit 0, match 0xFF, mode 0 -> wrap every 256 cycles
        tick_en = 1'b1;
        repeat (600) @(negedge clk);

        cur_tag = "R3 mode0";
        setup(2'd0, 8'd1, 8'd5, 8'd9);
        run_rand(1200, 80, 1'b1);

        cur_tag = "R4 mode1";
        setup(2'd1, 8'd2, 8'd3, 8'd6);
        run_rand(1200, 70, 1'b1);

        cur_tag = "R5 mode2";
        setup(2'd2, 8'd0, 8'd40, 8'd1);
        run_rand(1500, 90, 1'b0);

        cur_tag = "R6 mode3";
        setup(2'd3, 8'd0, 8'd12, 8'd0);
        run_rand(1200, 50, 1'b0);

        // R2 no prescaled movement while tick_en is low
        cur_tag = "R2 tick_en low";
        setup(2'd2, 8'd0, 8'hFF, 8'hFF);
        tick_en = 1'b1; repeat (7) @(negedge clk);
        tick_en = 1'b0; cap_a_in = 1'b1; @(negedge clk);
        cap_a_in = 1'b0; repeat (30) @(negedge clk);
        cap_b_in = 1'b1; @(negedge clk);
        cap_b_in = 1'b0;
        check(cap_a === cap_b && cap_a === 16'd7, "R2 frozen count", {cap_a, cap_b},
              {16'd7, 16'd7});

        // R7 match of zero: wraps on every tick
        cur_tag = "R7 match zero";
        setup(2'd0, 8'd0, 8'd0, 8'd0);
        tick_en = 1'b1; repeat (5) @(negedge clk);
        check(irq_lo && irq_hi, "R7 back-to-back wrap", {30'd0, irq_lo, irq_hi}, 32'd3);

        // R9 mode write clears; prescaler write does not
        cur_tag = "R9 clear";
        setup(2'd0, 8'd0, 8'd200, 8'd200);
        repeat (20) @(negedge clk);
        write_reg(2'd1, 8'd0);
        cap_a_in = 1'b1; @(negedge clk); cap_a_in = 1'b0;
        check(cap_a === {8'd21, 8'd21}, "R9 no clear on limit write", {16'd0, cap_a},
              {16'd0, 8'd21, 8'd21});
        write_reg(2'd0, 8'd0);
        cap_b_in = 1'b1; @(negedge clk); cap_b_in = 1'b0;
        check(cap_b === 16'd0, "R9 clear on mode write", {16'd0, cap_b}, 32'd0);
        run_rand(300, 60, 1'b1);

        checking = 1'b0;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule